// File: doc/BRIEF.md
# Canonical Huffman Codeword Generator

This block turns a list of per-symbol code lengths into canonical prefix codewords. A frame of `NUM_SYMS` symbol/length pairs is loaded over a valid/ready stream. The pairs may arrive in any symbol order, and each symbol appears exactly once. While the frame loads, the block counts how many symbols use each length from 1 to `MAX_LEN`. A length of 0 means the symbol is unused.

Once the frame is loaded, the block walks the lengths from the longest down to 1, taking one cycle per length. This pass sets a starting code for each length. The longest length is anchored at all-zeros. Each shorter start is derived from the next-longer start plus that length's symbol count, halved.

The block then visits every symbol in ascending order, one per cycle. Each used symbol takes the next free code of its length. The code is emitted bit-reversed over exactly its own length, together with the symbol and the length. After the last symbol the block is ready for the next frame.

Top module: `canon_code_gen`

## Requirements
- R1: After reset `inReady` is 1 and `outValid` is 0.
- R2: A frame is exactly `NUM_SYMS` accepted pairs, in any symbol order. `inReady` is 0 from the cycle after the last pair is accepted until the emission pass has visited every symbol.
- R3: The lowest-numbered symbol that has the longest length in use receives the canonical code 0.
- R4: Among symbols of equal length, the canonical code of each symbol is one more than that of the previous symbol of that length in ascending symbol order.
- R5: The starting code of length l is (start(l+1) + count(l+1)) >> 1, evaluated from length `MAX_LEN` downwards, with start(`MAX_LEN`) = 0.
- R6: For a complete length set (Kraft sum equal to 1), a shorter canonical code is numerically greater than the equally long leading part of any longer code.
- R7: `outCode` bit i equals canonical-code bit (L-1-i) for i < L, where L is `outLen`; bits at positions L and above are 0.
- R8: A symbol with length 0 produces no output. Every output has a length of 1 or more.
- R9: Outputs appear in ascending symbol order. A symbol visited in cycle t is presented in cycle t+1, and symbols adjacent in number with non-zero lengths appear in consecutive cycles.
- R10: Lengths up to `MAX_LEN` (27 by default) are supported, including two symbols at the maximum length.
- R11: Consecutive frames are independent: the length counts and starting codes of one frame do not affect the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Input pair valid |
| inSym | input | $clog2(NUM_SYMS) | Symbol index of the pair |
| inLen | input | $clog2(MAX_LEN+1) | Code length of the symbol, 0 = unused |
| inReady | output | 1 | Block is accepting pairs of a frame |
| outValid | output | 1 | Output triple valid |
| outSym | output | $clog2(NUM_SYMS) | Symbol of the emitted codeword |
| outLen | output | $clog2(MAX_LEN+1) | Length of the emitted codeword |
| outCode | output | MAX_LEN | Bit-reversed codeword, zero above `outLen` |

## Verification
The bench loads frames in a scrambled symbol order, with unused symbols scattered among the used ones:
- a flat set where every symbol has length 5;
- a small mixed set;
- a ladder reaching two codes of length 27;
- a lone code.

A design that anchored codes at the shortest length, or that forgot the halving between lengths, would give wrong codes and overlapping prefixes. A design that reversed over the full width would leave set bits above the length. A design that did not clear its counts would carry the first frame's starts into the second. Zero-length symbols that leaked through would show up as extra outputs with length 0.

// File: rtl/canon_code_pkg.sv
package canon_code_pkg;

  typedef enum logic [1:0] {
    PH_LOAD  = 2'd0,
    PH_START = 2'd1,
    PH_EMIT  = 2'd2
  } phase_t;

  // strobes from the control to the datapath
  typedef struct packed {
    logic store;  // write one length and bump its count
    logic step;   // compute one starting code
    logic emit;   // assign a code to one symbol
    logic clear;  // wipe counts at frame end
  } strobes_t;

endpackage

// File: rtl/canon_code_ctrl.sv
module canon_code_ctrl
  import canon_code_pkg::*;
#(
  parameter int NUM_SYMS = 32,
  parameter int MAX_LEN  = 27
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          inValid,
  output logic                          inReady,
  output strobes_t                      strobe,
  output logic [$clog2(MAX_LEN+1)-1:0]  lenIdx,
  output logic [$clog2(NUM_SYMS)-1:0]   symIdx
);
  localparam int SYM_W = $clog2(NUM_SYMS);
  localparam int LEN_W = $clog2(MAX_LEN + 1);
  localparam logic [SYM_W-1:0] LAST_SYM = SYM_W'(NUM_SYMS - 1);

  phase_t           phase;
  logic [SYM_W-1:0] loadCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase   <= PH_LOAD;
      loadCnt <= '0;
      lenIdx  <= '0;
      symIdx  <= '0;
    end else begin
      unique case (phase)
        PH_LOAD: if (inValid) begin
          if (loadCnt == LAST_SYM) begin
            loadCnt <= '0;
            phase   <= PH_START;
            lenIdx  <= LEN_W'(MAX_LEN);
          end else begin
            loadCnt <= loadCnt + 1'b1;
          end
        end
        PH_START: begin
          if (lenIdx == LEN_W'(1)) begin
            phase  <= PH_EMIT;
            symIdx <= '0;
          end else begin
            lenIdx <= lenIdx - 1'b1;
          end
        end
        PH_EMIT: begin
          if (symIdx == LAST_SYM) phase <= PH_LOAD;
          else                    symIdx <= symIdx + 1'b1;
        end
        default: phase <= PH_LOAD;
      endcase
    end
  end

  always_comb begin
    inReady      = (phase == PH_LOAD);
    strobe.store = (phase == PH_LOAD) && inValid;
    strobe.step  = (phase == PH_START);
    strobe.emit  = (phase == PH_EMIT);
    strobe.clear = (phase == PH_EMIT) && (symIdx == LAST_SYM);
  end

endmodule

// File: rtl/canon_code_dp.sv
module canon_code_dp
  import canon_code_pkg::*;
#(
  parameter int NUM_SYMS = 32,
  parameter int MAX_LEN  = 27
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  strobes_t                      strobe,
  input  logic [$clog2(NUM_SYMS)-1:0]   inSym,
  input  logic [$clog2(MAX_LEN+1)-1:0]  inLen,
  input  logic [$clog2(MAX_LEN+1)-1:0]  lenIdx,
  input  logic [$clog2(NUM_SYMS)-1:0]   symIdx,
  output logic                          outValid,
  output logic [$clog2(NUM_SYMS)-1:0]   outSym,
  output logic [$clog2(MAX_LEN+1)-1:0]  outLen,
  output logic [MAX_LEN-1:0]            outCode
);
  localparam int SYM_W  = $clog2(NUM_SYMS);
  localparam int LEN_W  = $clog2(MAX_LEN + 1);
  localparam int CODE_W = MAX_LEN;
  localparam int CNT_W  = $clog2(NUM_SYMS + 1);

  logic [LEN_W-1:0]  lenMem   [NUM_SYMS];
  logic [CNT_W-1:0]  counts   [1:MAX_LEN];
  logic [CODE_W-1:0] nextCode [1:MAX_LEN];
  logic [CODE_W-1:0] run;
  logic [CODE_W:0]   runSum;
  logic [LEN_W-1:0]  lenCur;

  // reverse the low n bits of c, clear the rest
  function automatic logic [CODE_W-1:0] revLow(input logic [CODE_W-1:0] c,
                                               input logic [LEN_W-1:0]  n);
    logic [CODE_W-1:0] r;
    r = '0;
    for (int i = 0; i < CODE_W; i++) begin
      if (i < int'(n)) r[i] = c[int'(n) - 1 - i];
    end
    return r;
  endfunction

  assign lenCur = lenMem[symIdx];
  assign runSum = {1'b0, run} + (CODE_W+1)'(counts[lenIdx]);

  always_ff @(posedge clk) begin
    if (strobe.store) lenMem[inSym] <= inLen;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      run      <= '0;
      outValid <= 1'b0;
      outSym   <= '0;
      outLen   <= '0;
      outCode  <= '0;
      for (int l = 1; l <= MAX_LEN; l++) begin
        counts[l]   <= '0;
        nextCode[l] <= '0;
      end
    end else begin
      outValid <= 1'b0;
      if (strobe.store && inLen != '0)
        counts[inLen] <= counts[inLen] + 1'b1;
      if (strobe.step) begin
        nextCode[lenIdx] <= run;
        run              <= runSum[CODE_W:1];
      end
      if (strobe.emit) begin
        outSym   <= symIdx;
        outLen   <= lenCur;
        outValid <= (lenCur != '0);
        if (lenCur != '0) begin
          outCode          <= revLow(nextCode[lenCur], lenCur);
          nextCode[lenCur] <= nextCode[lenCur] + 1'b1;
        end
      end
      if (strobe.clear) begin
        run <= '0;
        for (int l = 1; l <= MAX_LEN; l++) counts[l] <= '0;
      end
    end
  end

endmodule

// File: rtl/canon_code_gen.sv
module canon_code_gen
  import canon_code_pkg::*;
#(
  parameter int NUM_SYMS = 32,
  parameter int MAX_LEN  = 27
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          inValid,
  input  logic [$clog2(NUM_SYMS)-1:0]   inSym,
  input  logic [$clog2(MAX_LEN+1)-1:0]  inLen,
  output logic                          inReady,
  output logic                          outValid,
  output logic [$clog2(NUM_SYMS)-1:0]   outSym,
  output logic [$clog2(MAX_LEN+1)-1:0]  outLen,
  output logic [MAX_LEN-1:0]            outCode
);
  localparam int SYM_W = $clog2(NUM_SYMS);
  localparam int LEN_W = $clog2(MAX_LEN + 1);

  strobes_t         strobe;
  logic [LEN_W-1:0] lenIdx;
  logic [SYM_W-1:0] symIdx;

  canon_code_ctrl #(.NUM_SYMS(NUM_SYMS), .MAX_LEN(MAX_LEN)) u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
    .strobe(strobe), .lenIdx(lenIdx), .symIdx(symIdx)
  );

  canon_code_dp #(.NUM_SYMS(NUM_SYMS), .MAX_LEN(MAX_LEN)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .inSym(inSym), .inLen(inLen),
    .lenIdx(lenIdx), .symIdx(symIdx), .outValid(outValid), .outSym(outSym),
    .outLen(outLen), .outCode(outCode)
  );

endmodule

// File: rtl/canon_code_checks.sv
module canon_code_checks #(
  parameter int NUM_SYMS = 32,
  parameter int MAX_LEN  = 27
) (
  input logic                          clk,
  input logic                          rstN,
  input logic                          inReady,
  input logic                          outValid,
  input logic [$clog2(NUM_SYMS)-1:0]   outSym,
  input logic [$clog2(MAX_LEN+1)-1:0]  outLen,
  input logic [MAX_LEN-1:0]            outCode
);
  localparam int LEN_W = $clog2(MAX_LEN + 1);

  a_r8_len_nonzero: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> outLen != '0);

  a_r10_len_bound: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> outLen <= LEN_W'(MAX_LEN));

  a_r7_high_bits_zero: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (outCode >> outLen) == '0);

  a_r9_adjacent_order: assert property (@(posedge clk) disable iff (!rstN)
    outValid && $past(outValid) |-> outSym == $past(outSym) + 1'b1);

  a_r2_busy_while_emitting: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> !$past(inReady));

endmodule

bind canon_code_gen canon_code_checks #(.NUM_SYMS(NUM_SYMS), .MAX_LEN(MAX_LEN)) u_checks (
  .clk(clk), .rstN(rstN), .inReady(inReady), .outValid(outValid),
  .outSym(outSym), .outLen(outLen), .outCode(outCode)
);

// File: tb/tb_canon_code_gen.sv
`timescale 1ns/1ps
module tb_canon_code_gen;
  localparam int NS = 32;
  localparam int ML = 27;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0;
  logic [4:0] inSym = '0;
  logic [4:0] inLen = '0;
  logic inReady, outValid;
  logic [4:0] outSym, outLen;
  logic [ML-1:0] outCode;

  always #5 clk = ~clk;

  canon_code_gen #(.NUM_SYMS(NS), .MAX_LEN(ML)) dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inSym(inSym), .inLen(inLen),
    .inReady(inReady), .outValid(outValid), .outSym(outSym), .outLen(outLen),
    .outCode(outCode)
  );

  int checks = 0;
  int failures = 0;
  int lenOf [NS];
  int expSym[$], expLen[$], expCode[$];
  int recN;
  int recLen [NS];
  int recCode [NS];

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int revBits(input int c, input int n);
    int r = 0;
    for (int i = 0; i < n; i++) if (((c >> (n - 1 - i)) & 1) != 0) r |= (1 << i);
    return r;
  endfunction

  // behavioural model: counts, starts from the longest length, ascending walk
  task automatic buildExpected();
    int cnt [ML+1];
    int nxt [ML+1];
    int run = 0;
    for (int l = 0; l <= ML; l++) cnt[l] = 0;
    for (int s = 0; s < NS; s++) cnt[lenOf[s]]++;
    for (int l = ML; l >= 1; l--) begin
      nxt[l] = run;
      run = (run + cnt[l]) >> 1;
    end
    for (int s = 0; s < NS; s++) begin
      if (lenOf[s] != 0) begin
        expSym.push_back(s);
        expLen.push_back(lenOf[s]);
        expCode.push_back(revBits(nxt[lenOf[s]], lenOf[s]));
        nxt[lenOf[s]]++;
      end
    end
  endtask

  // compare every clock against the model queue
  always @(negedge clk) begin
    if (rstN && outValid) begin
      if (expSym.size() == 0) begin
        check(1'b0, "R8 unexpected output", outSym, -1);
      end else begin
        int s, l, c;
        s = expSym.pop_front();
        l = expLen.pop_front();
        c = expCode.pop_front();
        check(int'(outSym) == s, "R9 symbol order", outSym, s);
        check(int'(outLen) == l, "R8 length", outLen, l);
        check(int'(outCode) == c, "R5 R7 reversed code", outCode, c);
        if (recN < NS) begin
          recLen[recN]  = int'(outLen);
          recCode[recN] = revBits(int'(outCode), int'(outLen));
          recN++;
        end
      end
    end
  end

  task automatic runFrame(input bit complete);
    int maxL = 0;
    int last [ML+1];
    bit seen [ML+1];
    bit bad;
    int nz = 0;
    recN = 0;
    buildExpected();
    for (int s = 0; s < NS; s++) begin
      if (lenOf[s] > maxL) maxL = lenOf[s];
      if (lenOf[s] != 0) nz++;
    end
    for (int i = 0; i < NS; i++) begin
      int s = (i * 7 + 3) % NS;
      @(negedge clk);
      inValid = 1'b1;
      inSym = 5'(s);
      inLen = 5'(lenOf[s]);
    end
    @(negedge clk);
    inValid = 1'b0;
    check(inReady == 1'b0, "R2 busy after last pair", inReady, 0);
    while (!(inReady && expSym.size() == 0)) @(negedge clk);
    @(negedge clk);
    check(recN == nz, "R2 R8 output count", recN, nz);
    // R3: first code of the longest length is zero
    for (int k = 0; k < recN; k++) begin
      if (recLen[k] == maxL) begin
        check(recCode[k] == 0, "R3 longest starts at zero", recCode[k], 0);
        break;
      end
    end
    // R4: consecutive within a length
    for (int l = 0; l <= ML; l++) seen[l] = 1'b0;
    bad = 1'b0;
    for (int k = 0; k < recN; k++) begin
      if (seen[recLen[k]] && recCode[k] != last[recLen[k]] + 1) bad = 1'b1;
      seen[recLen[k]] = 1'b1;
      last[recLen[k]] = recCode[k];
    end
    check(!bad, "R4 increment within length", bad, 0);
    if (complete) begin
      bad = 1'b0;
      for (int a = 0; a < recN; a++)
        for (int b = 0; b < recN; b++)
          if (recLen[a] < recLen[b] &&
              !(recCode[a] > (recCode[b] >> (recLen[b] - recLen[a])))) bad = 1'b1;
      check(!bad, "R6 shorter code above longer prefix", bad, 0);
    end
  endtask

  task automatic finishRun();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    check(1'b0, "watchdog expired", 0, 1);
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    check(inReady == 1'b1, "R1 reset inReady", inReady, 1);
    check(outValid == 1'b0, "R1 reset outValid", outValid, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(inReady == 1'b1, "R1 ready after reset", inReady, 1);

    // flat: all length 5
    for (int s = 0; s < NS; s++) lenOf[s] = 5;
    runFrame(1'b1);

    // mixed small set, back to back with the previous frame (R11)
    for (int s = 0; s < NS; s++) lenOf[s] = 0;
    lenOf[3] = 2; lenOf[9] = 2; lenOf[0] = 3; lenOf[20] = 3;
    lenOf[31] = 3; lenOf[5] = 4; lenOf[12] = 4;
    runFrame(1'b1);

    // ladder reaching two length-27 codes (R10)
    for (int s = 0; s < NS; s++) lenOf[s] = 0;
    for (int j = 0; j < 28; j++) lenOf[(j * 5) % NS] = (j < 26) ? j + 1 : ML;
    runFrame(1'b1);

    // lone code
    for (int s = 0; s < NS; s++) lenOf[s] = 0;
    lenOf[17] = 1;
    runFrame(1'b0);

    // repeat flat frame to show no carry-over (R11)
    for (int s = 0; s < NS; s++) lenOf[s] = 5;
    runFrame(1'b1);

    finishRun();
  end

endmodule